// File: doc/BRIEF.md
# Two-Byte Queued Funnel Shifter

This peripheral sits on a small CPU's I/O space and offloads the bit shifting needed to draw graphics at arbitrary pixel positions. The CPU pushes bytes into a two-deep history through a data port. Each push moves the byte that was newest into an older slot. The two retained bytes form a 16-bit word, with the newest byte in the upper half.

A second port sets a 3-bit offset. Reading the result port returns a byte-wide window cut from that word. At offset 0 the window is the newest byte. Each step of the offset slides the window one bit down toward the older byte.

The slave interface carries a port number, write and read strobes, a write bus and a read bus. The read bus is driven to zero whenever the result port is not being read, so it can be ORed onto a shared bus.

Top module: `funnel_shifter_q2`

## Requirements
- R1: After reset both byte slots and the offset are zero, so a read of port 3 returns 0x00.
- R2: A write to port 4 stores the bus byte as the newest byte and moves the previous newest byte into the older slot in the same write, so two writes fill the word.
- R3: A write to port 2 latches bus bits 2..0 as the offset (0 to 7); bits 7..3 are ignored.
- R4: A read of port 3 returns bits (15-k) down to (8-k) of the word {newest, older}, where k is the offset; output bit i is word bit 8+i-k.
- R5: With offset 0 a read of port 3 returns the newest byte unchanged.
- R6: Bit 0 of the older byte never reaches the read data; at offset 7 the read data is {newest[0], older[7:1]}.
- R7: Writes to any port other than 2 and 4 leave both byte slots and the offset unchanged.
- R8: The read data is 0x00 whenever port 3 is not being read, including reads of other ports.
- R9: The offset keeps its value across writes to port 4 until port 2 is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_i | input | 8 | I/O port number of the current access |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, a combinational window while port 3 is read, else zero |

## Verification
The bench checks offset 7, where a design that indexed the word off by one would leak bit 0 of the older byte or drop bit 0 of the newest byte. It writes 0xFF to the offset port, which catches a design that latched more than three bits or wrapped the offset wrongly. It checks that the offset survives queue pushes and that stray-port writes do nothing. A design that decoded ports loosely would corrupt the word or reload the offset there. Reads of other ports and idle cycles must give zero. A design that left the window on the bus would show nonzero data there.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFFS_W = $clog2(DATA_W);
  localparam int unsigned PORT_W = 8;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [OFFS_W-1:0] offs_t;
  typedef logic [PORT_W-1:0] port_t;
endpackage

// File: rtl/fsh_port_dec.sv
module fsh_port_dec
  import fsh_pkg::*;
#(
  parameter port_t PUSH_PORT = 8'd4,
  parameter port_t OFFS_PORT = 8'd2,
  parameter port_t READ_PORT = 8'd3
) (
  input  port_t port_i,
  input  logic  wr_i,
  input  logic  rd_i,
  output logic  push_o,
  output logic  offs_ld_o,
  output logic  rd_sel_o
);
  assign push_o    = wr_i && (port_i == PUSH_PORT);
  assign offs_ld_o = wr_i && (port_i == OFFS_PORT);
  assign rd_sel_o  = rd_i && (port_i == READ_PORT);
endmodule

// File: rtl/fsh_byte_queue.sv
module fsh_byte_queue
  import fsh_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  byte_t data_i,
  output logic [DEPTH*DATA_W-1:0] word_o
);
  byte_t slot_q [DEPTH];

  // slot 0 is newest; generate chain shifts toward older slots
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     slot_q[s] <= '0;
      else if (push_i) slot_q[s] <= (s == 0) ? data_i : slot_q[(s == 0) ? 0 : s-1];
    end
    assign word_o[(DEPTH-s)*DATA_W-1 -: DATA_W] = slot_q[s];
  end

  a_r2_push_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (slot_q[0] == $past(data_i)) && (slot_q[1] == $past(slot_q[0])));

  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(slot_q[0]) && $stable(slot_q[1]));
endmodule

// File: rtl/fsh_offset_reg.sv
module fsh_offset_reg
  import fsh_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  byte_t data_i,
  output offs_t offs_o
);
  offs_t offs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     offs_q <= '0;
    else if (load_i) offs_q <= data_i[OFFS_W-1:0];
  end
  assign offs_o = offs_q;

  a_r3_load_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> offs_o == $past(data_i[OFFS_W-1:0]));

  a_r9_offs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(offs_o));
endmodule

// File: rtl/fsh_window_sel.sv
module fsh_window_sel
  import fsh_pkg::*;
(
  input  logic [2*DATA_W-1:0] word_i,
  input  offs_t               offs_i,
  input  logic                en_i,
  output byte_t               win_o
);
  // output bit i takes word bit DATA_W + i - offset
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic [DATA_W-1:0] cand;
    for (genvar k = 0; k < DATA_W; k++) begin : g_cand
      assign cand[k] = word_i[DATA_W + i - k];
    end
    assign win_o[i] = en_i & cand[offs_i];
  end
endmodule

// File: rtl/funnel_shifter_q2.sv
module funnel_shifter_q2
  import fsh_pkg::*;
#(
  parameter logic [7:0] PUSH_PORT = 8'd4,
  parameter logic [7:0] OFFS_PORT = 8'd2,
  parameter logic [7:0] READ_PORT = 8'd3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] port_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic push, offs_ld, rd_sel;
  logic [2*DATA_W-1:0] word;
  offs_t offs;

  fsh_port_dec #(
    .PUSH_PORT(PUSH_PORT), .OFFS_PORT(OFFS_PORT), .READ_PORT(READ_PORT)
  ) i_dec (
    .port_i(port_i), .wr_i(wr_i), .rd_i(rd_i),
    .push_o(push), .offs_ld_o(offs_ld), .rd_sel_o(rd_sel)
  );

  fsh_byte_queue #(.DEPTH(2)) i_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .data_i(wdata_i), .word_o(word)
  );

  fsh_offset_reg i_offs (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(offs_ld), .data_i(wdata_i), .offs_o(offs)
  );

  fsh_window_sel i_win (
    .word_i(word), .offs_i(offs), .en_i(rd_sel), .win_o(rdata_o)
  );

  a_r5_offs_zero_newest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel && offs == '0) |-> rdata_o == word[2*DATA_W-1:DATA_W]);

  a_r6_older_lsb_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel && offs == offs_t'(DATA_W-1)) |-> (rdata_o[0] == word[1]) && (rdata_o[DATA_W-1] == word[DATA_W]));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && port_i == READ_PORT) |-> rdata_o == '0);
endmodule

// File: tb/test_funnel_shifter_q2.sv
`timescale 1ns/1ps
module test_funnel_shifter_q2;
  logic clk = 0, rst_ni = 0, wr = 0, rd = 0;
  logic [7:0] port = 0, wdata = 0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  funnel_shifter_q2 i_funnel_shifter_q2 (
    .clk_i(clk), .rst_ni(rst_ni), .port_i(port), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  // {is_write, port, data, expected read}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'd4, 8'hA5, 8'h00},
    {1'b0, 8'd3, 8'h00, 8'hA5},   // R5 offset 0
    {1'b1, 8'd2, 8'h03, 8'h00},
    {1'b0, 8'd3, 8'h00, 8'h28},   // R4 word A500, k=3
    {1'b1, 8'd4, 8'h3C, 8'h00},   // R2
    {1'b0, 8'd3, 8'h00, 8'hE5},   // R4 word 3CA5, k=3
    {1'b1, 8'd2, 8'hFF, 8'h00},   // R3 upper bits dropped
    {1'b0, 8'd3, 8'h00, 8'h52},   // R6 k=7
    {1'b1, 8'd4, 8'h81, 8'h00},   // R9 offset kept
    {1'b0, 8'd3, 8'h00, 8'h9E},
    {1'b1, 8'd6, 8'h55, 8'h00},   // R7 stray port
    {1'b0, 8'd3, 8'h00, 8'h9E},
    {1'b0, 8'd5, 8'h00, 8'h00}    // R8 other read port
  };

  task automatic do_write(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk); port = p; wdata = d; wr = 1;
    @(negedge clk); wr = 0; port = 0; wdata = 0;
  endtask

  task automatic check_read(input logic [7:0] p, input logic [7:0] exp, input string req);
    @(negedge clk); port = p; rd = 1;
    #2;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s port %0d got %02h expected %02h", req, p, rdata, exp);
    end
    @(negedge clk); rd = 0; port = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    check_read(8'd3, 8'h00, "R1 reset read");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) do_write(VEC[v][23:16], VEC[v][15:8]);
      else check_read(VEC[v][23:16], VEC[v][7:0], "R4 table vector");
    end

    // R8 idle bus with no strobe
    @(negedge clk); #2; checks++;
    if (rdata !== 8'h00) begin errors++; $display("FAIL R8 idle got %02h expected 00", rdata); end

    // R3 offset from bits 2..0: 0x0C gives 4
    do_write(8'd2, 8'h0C);
    check_read(8'd3, 8'h13, "R3 offset 4 on word 813C");
    do_write(8'd2, 8'h00);
    check_read(8'd3, 8'h81, "R5 offset 0 newest");

    // R6 older bit 0 unreachable
    do_write(8'd4, 8'h01);
    do_write(8'd4, 8'h00);
    do_write(8'd2, 8'h07);
    check_read(8'd3, 8'h00, "R6 older lsb hidden");
    do_write(8'd4, 8'hFF);
    do_write(8'd4, 8'h00);
    check_read(8'd3, 8'h7F, "R6 k=7 window");

    // R7 stray write with offset-like and data-like values
    do_write(8'd0, 8'h12);
    do_write(8'd1, 8'h00);
    check_read(8'd3, 8'h7F, "R7 stray writes ignored");

    // R1 reset mid-run clears slots and offset
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    check_read(8'd3, 8'h00, "R1 slots cleared");
    do_write(8'd4, 8'h80);
    check_read(8'd3, 8'h80, "R1 offset cleared");

    // R2 two writes fill the word
    do_write(8'd4, 8'hC3);
    do_write(8'd2, 8'h04);
    check_read(8'd3, 8'h38, "R2 word C380 k=4");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule